// File: doc/BRIEF.md
# Lockable Two-Way Data Cache

This block is a small two-way set-associative data cache between a CPU load/store port and a slower memory. Each line holds four 32-bit words (16 bytes). Reads that hit answer in the cycle they are presented. Reads that miss fetch the whole line from memory with a four-beat refill. Writes to ordinary lines go straight through to memory.

Locking is not tied to an address range. While the global `lock_en` input is high, a line brought in by a read miss is marked locked, provided neither way of its set already holds a lock. A locked line is never chosen for replacement. Writes that hit a valid locked line stay inside the cache and produce no memory traffic.

Software manages the arrays through three commands addressed by set index and way:
- invalidate one line;
- clear one line's lock bit;
- invalidate every unlocked line.

Invalidating a locked line without first clearing its lock leaves a mixed state: reads still hit, but writes again reach memory. A change on `cache_en` is picked up only when the controller is idle, so a refill already in flight finishes under the old setting.

Top module: `lkc_top`

## Requirements
- R1: After a synchronous active-low reset, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low and every line is invalid and unlocked.
- R2: A read hit raises `cpu_ready` in the same cycle with the stored word and makes no memory access. A read miss raises `mem_rd_req` with the line-aligned address held steady. It takes four `mem_rd_valid` beats in word order 0..3 and holds `cpu_ready` low until the last beat is taken. It then answers one cycle later.
- R3: A write to an unlocked line, hit or miss, issues one memory write of the same address and data, held until `mem_wr_ack`. A write hit also updates the cache. A write miss allocates nothing.
- R4: On a read miss the victim is the first way (0 before 1) that is neither valid nor locked. Failing that, it is the unlocked way when the other is locked. Failing that, it is the way not touched most recently; every hit and every fill touches a way.
- R5: A line filled while `lock_en` is high becomes locked only if neither way of its set is locked. A second fill into that set stays unlocked, and at most one way per set is ever locked.
- R6: A write that hits a valid locked line updates only the cache, with `cpu_ready` high in the cycle it is presented and no memory write.
- R7: A locked way is never replaced, and its data stays readable across misses to the same set.
- R8: `maint_op` encodings are 0 none, 1 invalidate the line at `maint_idx`/`maint_way`, 2 clear that line's lock, and 3 invalidate all. Invalidate-all leaves locked lines valid.
- R9: After an index invalidate of a locked line whose lock was not cleared, reads of that address still hit. Writes to it go to memory and also update the cached word.
- R10: A lock clear makes no memory write. The line stays valid and keeps its cache-only data, and later writes to it go through to memory.
- R11: While the cache is disabled, every read refills from memory without allocating and every write goes to memory. A change on `cache_en` takes effect only once the controller is idle.
- R12: A non-zero `maint_op` is applied only when the controller is idle. In that cycle it takes precedence over a CPU request, which is held with `cpu_ready` low and served afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable, sampled while idle |
| lock_en | input | 1 | Lock newly filled lines |
| maint_op | input | 2 | Maintenance command (0 none, 1 invalidate line, 2 clear lock, 3 invalidate all) |
| maint_idx | input | $clog2(SETS) | Set index for maintenance |
| maint_way | input | 1 | Way for maintenance |
| cpu_req | input | 1 | CPU request valid, held until ready |
| cpu_we | input | 1 | CPU request is a write |
| cpu_addr | input | ADDR_W | CPU byte address (word aligned) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_rd_req | output | 1 | Line refill request |
| mem_rd_addr | output | ADDR_W | Line-aligned refill address |
| mem_rd_valid | input | 1 | Refill beat valid |
| mem_rd_data | input | 32 | Refill beat word |
| mem_wr_req | output | 1 | Single-word write request |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ack | input | 1 | Write accepted |

## Verification
The bench builds the cache with four sets and 32-bit addresses. With only four sets, addresses 64 bytes apart land in the same set. A handful of lines therefore exercises LRU replacement, the one-lock-per-set rule, and a locked way surviving repeated misses. The memory model answers refill beats and write acknowledgements every other cycle. This keeps refills long enough to change `cache_en` in the middle of one and to see `cpu_ready` held.

// File: rtl/lkc_pkg.sv
// Shared encodings for the lockable cache.
// Assumes two ways per set and four 32-bit words per line.
package lkc_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int WOFS_W     = $clog2(LINE_WORDS);
    localparam int LINE_LSB   = WOFS_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_RESP  = 2'd2,
        ST_WRITE = 2'd3
    } lkc_state_e;

    typedef enum logic [1:0] {
        MT_NONE     = 2'd0,
        MT_INV_IDX  = 2'd1,
        MT_LOCK_CLR = 2'd2,
        MT_INV_ALL  = 2'd3
    } lkc_maint_e;
endpackage

// File: rtl/lkc_tag_store.sv
// Tag, valid, lock and LRU state for a two-way cache.
// Looks up one set combinationally and applies fill, touch and maintenance updates.
// Assumes the caller never issues a fill and a maintenance command in the same cycle.
module lkc_tag_store #(
    parameter int SETS  = 4,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [1:0]       hit_o,
    output logic [1:0]       valid_o,
    output logic [1:0]       lock_o,
    output logic             lru_o,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_lock,
    input  logic             touch_we,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way,
    input  logic [1:0]       mt_op,
    input  logic [IDX_W-1:0] mt_idx,
    input  logic             mt_way
);
    import lkc_pkg::*;

    logic [TAG_W-1:0] tag_q   [SETS][2];
    logic [1:0]       valid_q [SETS];
    logic [1:0]       lock_q  [SETS];
    logic [SETS-1:0]  lru_q;

    // Tag capture on fill (no reset needed, guarded by valid/lock)
    always_ff @(posedge clk) begin
        if (fill_we) tag_q[fill_idx][fill_way] <= fill_tag;
    end

    // Valid, lock and LRU state updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_we) begin
                valid_q[fill_idx][fill_way] <= 1'b1;
                lock_q[fill_idx][fill_way]  <= fill_lock;
                lru_q[fill_idx]             <= ~fill_way;
            end
            if (touch_we) lru_q[touch_idx] <= ~touch_way;
            case (lkc_maint_e'(mt_op))
                MT_INV_IDX:  valid_q[mt_idx][mt_way] <= 1'b0;
                MT_LOCK_CLR: lock_q[mt_idx][mt_way]  <= 1'b0;
                MT_INV_ALL:  for (int s = 0; s < SETS; s++) valid_q[s] <= valid_q[s] & lock_q[s];
                default: ;
            endcase
        end
    end

    // Per-way match: a locked line still matches after its valid bit is cleared
    for (genvar w = 0; w < 2; w++) begin : g_way
        assign hit_o[w] = (valid_q[lk_idx][w] | lock_q[lk_idx][w]) &&
                          (tag_q[lk_idx][w] == lk_tag);
    end

    assign valid_o = valid_q[lk_idx];
    assign lock_o  = lock_q[lk_idx];
    assign lru_o   = lru_q[lk_idx];
endmodule

// File: rtl/lkc_victim.sv
// Chooses the way to refill and whether the new line is locked.
// Assumes at most one way per set is locked, so a victim always exists.
module lkc_victim (
    input  logic [1:0] valid,
    input  logic [1:0] lock,
    input  logic       lru,
    input  logic       lock_en,
    output logic       way,
    output logic       lock_grant
);
    logic [1:0] free;
    assign free = ~valid & ~lock;

    // Priority: free way, then the unlocked way, then LRU
    always_comb begin
        if (free[0])      way = 1'b0;
        else if (free[1]) way = 1'b1;
        else if (lock[0]) way = 1'b1;
        else if (lock[1]) way = 1'b0;
        else              way = lru;
    end

    assign lock_grant = lock_en && (lock == 2'b00);
endmodule

// File: rtl/lkc_data_store.sv
// Word storage for all lines; one combinational read port and one write port.
// Assumes four words per line and two ways.
module lkc_data_store #(
    parameter int SETS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int AW    = IDX_W + 1 + lkc_pkg::WOFS_W,
    localparam int DEPTH = SETS * 2 * lkc_pkg::LINE_WORDS
) (
    input  logic                      clk,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic                      rd_way,
    input  logic [lkc_pkg::WOFS_W-1:0] rd_wofs,
    output logic [lkc_pkg::WORD_W-1:0] rd_data,
    input  logic                      we,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_way,
    input  logic [lkc_pkg::WOFS_W-1:0] wr_wofs,
    input  logic [lkc_pkg::WORD_W-1:0] wr_data
);
    logic [lkc_pkg::WORD_W-1:0] mem_q [DEPTH];
    logic [AW-1:0] rd_a, wr_a;

    assign rd_a    = {rd_idx, rd_way, rd_wofs};
    assign wr_a    = {wr_idx, wr_way, wr_wofs};
    assign rd_data = mem_q[rd_a];

    // Single word write
    always_ff @(posedge clk) begin
        if (we) mem_q[wr_a] <= wr_data;
    end
endmodule

// File: rtl/lkc_top.sv
// Lockable two-way write-through data cache with index-based maintenance.
// Assumes word-aligned CPU addresses and that the CPU holds each request until ready.
module lkc_top #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              lock_en,
    input  logic [1:0]        maint_op,
    input  logic [IDX_W-1:0]  maint_idx,
    input  logic              maint_way,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ack
);
    import lkc_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W - LINE_LSB;

    lkc_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       wdata_q, rdata_q;
    logic [WOFS_W-1:0] beat_q;
    logic              en_q, way_q, alloc_q, lockg_q;

    logic [1:0]        hit_w, valid_w, lock_w;
    logic              lru_w, v_way, v_lock;
    logic [31:0]       arr_rdata;
    logic              is_idle, maint_act, acc, hit_any, hit_way, cache_only;
    logic              dwe, fill_done;
    logic [IDX_W-1:0]  dw_idx;
    logic              dw_way;
    logic [WOFS_W-1:0] dw_wofs;
    logic [31:0]       dw_data;

    wire [WOFS_W-1:0] c_wofs = cpu_addr[2 +: WOFS_W];
    wire [IDX_W-1:0]  c_idx  = cpu_addr[LINE_LSB +: IDX_W];
    wire [TAG_W-1:0]  c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    wire [WOFS_W-1:0] q_wofs = addr_q[2 +: WOFS_W];
    wire [IDX_W-1:0]  q_idx  = addr_q[LINE_LSB +: IDX_W];
    wire [TAG_W-1:0]  q_tag  = addr_q[ADDR_W-1 -: TAG_W];

    // Request decode in the idle state
    always_comb begin
        is_idle    = (state_q == ST_IDLE);
        maint_act  = is_idle && (maint_op != MT_NONE);
        acc        = is_idle && cpu_req && !maint_act;
        hit_any    = en_q && (|hit_w);
        hit_way    = hit_w[1];
        cache_only = hit_any && valid_w[hit_way] && lock_w[hit_way];
        fill_done  = (state_q == ST_FILL) && mem_rd_valid && (beat_q == WOFS_W'(LINE_WORDS-1));
    end

    // Data array write source: CPU write hit or refill beat
    always_comb begin
        dwe     = 1'b0;
        dw_idx  = c_idx;
        dw_way  = hit_way;
        dw_wofs = c_wofs;
        dw_data = cpu_wdata;
        if (acc && cpu_we && hit_any) begin
            dwe = 1'b1;
        end else if ((state_q == ST_FILL) && mem_rd_valid && alloc_q) begin
            dwe     = 1'b1;
            dw_idx  = q_idx;
            dw_way  = way_q;
            dw_wofs = beat_q;
            dw_data = mem_rd_data;
        end
    end

    lkc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(c_idx), .lk_tag(c_tag),
        .hit_o(hit_w), .valid_o(valid_w), .lock_o(lock_w), .lru_o(lru_w),
        .fill_we(fill_done && alloc_q), .fill_idx(q_idx), .fill_way(way_q),
        .fill_tag(q_tag), .fill_lock(lockg_q),
        .touch_we(acc && hit_any), .touch_idx(c_idx), .touch_way(hit_way),
        .mt_op(is_idle ? maint_op : 2'd0), .mt_idx(maint_idx), .mt_way(maint_way)
    );

    lkc_victim u_victim (
        .valid(valid_w), .lock(lock_w), .lru(lru_w), .lock_en(lock_en),
        .way(v_way), .lock_grant(v_lock)
    );

    lkc_data_store #(.SETS(SETS)) u_data (
        .clk(clk),
        .rd_idx(c_idx), .rd_way(hit_way), .rd_wofs(c_wofs), .rd_data(arr_rdata),
        .we(dwe), .wr_idx(dw_idx), .wr_way(dw_way), .wr_wofs(dw_wofs), .wr_data(dw_data)
    );

    // Controller state, captured request and enable sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            beat_q  <= '0;
            en_q    <= 1'b0;
            way_q   <= 1'b0;
            alloc_q <= 1'b0;
            lockg_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    en_q <= cache_en;
                    if (acc && !cpu_we && !hit_any) begin
                        state_q <= ST_FILL;
                        addr_q  <= cpu_addr;
                        way_q   <= v_way;
                        alloc_q <= en_q;
                        lockg_q <= v_lock;
                        beat_q  <= '0;
                    end else if (acc && cpu_we && !cache_only) begin
                        state_q <= ST_WRITE;
                        addr_q  <= cpu_addr;
                        wdata_q <= cpu_wdata;
                    end
                end
                ST_FILL: if (mem_rd_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == q_wofs) rdata_q <= mem_rd_data;
                    if (fill_done) state_q <= ST_RESP;
                end
                ST_RESP:  state_q <= ST_IDLE;
                ST_WRITE: if (mem_wr_ack) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs
    always_comb begin
        case (state_q)
            ST_IDLE:  cpu_ready = acc && (cpu_we ? cache_only : hit_any);
            ST_RESP:  cpu_ready = 1'b1;
            ST_WRITE: cpu_ready = mem_wr_ack;
            default:  cpu_ready = 1'b0;
        endcase
        cpu_rdata   = is_idle ? arr_rdata : rdata_q;
        mem_rd_req  = (state_q == ST_FILL);
        mem_rd_addr = {addr_q[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
        mem_wr_req  = (state_q == ST_WRITE);
        mem_wr_addr = addr_q;
        mem_wr_data = wdata_q;
    end
endmodule

// File: rtl/lkc_checker.sv
// Temporal checks on the cache ports and array outputs; bound into lkc_top.
module lkc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic [1:0]        maint_op,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              mem_wr_req,
    input logic              mem_wr_ack,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [31:0]       mem_wr_data,
    input logic              is_idle,
    input logic              en_q,
    input logic [1:0]        hit_w,
    input logic [1:0]        valid_w,
    input logic [1:0]        lock_w
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_rd_req && !mem_wr_req && !cpu_ready));

    assert_refill_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_write_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    assert_one_lock_per_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lock_w) <= 1);

    assert_locked_write_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && cpu_req && cpu_we && maint_op == 2'd0 && en_q && |(hit_w & valid_w & lock_w))
        |=> !mem_wr_req);

    assert_enable_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && $past(mem_rd_req)) |-> $stable(en_q));

    assert_maint_stalls_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && maint_op != 2'd0) |-> !cpu_ready);
endmodule

bind lkc_top lkc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
    .maint_op(maint_op), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .is_idle(is_idle),
    .en_q(en_q), .hit_w(hit_w), .valid_w(valid_w), .lock_w(lock_w)
);

// File: tb/lkc_top_bench.sv
module lkc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 4;
    localparam int IDX_W = $clog2(SETS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cache_en = 1'b0, lock_en = 1'b0;
    logic [1:0] maint_op = 2'd0;
    logic [IDX_W-1:0] maint_idx = '0;
    logic maint_way = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic cpu_ready;
    logic [31:0] cpu_rdata;
    logic mem_rd_req, mem_wr_req;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data, mem_rd_data;
    logic mem_rd_valid, mem_wr_ack;

    logic [31:0] mem [256];
    logic [2:0] beat;
    int rd_cnt, wr_cnt;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lkc_top #(.ADDR_W(32), .SETS(SETS)) u_lkc_top (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .lock_en(lock_en),
        .maint_op(maint_op), .maint_idx(maint_idx), .maint_way(maint_way),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    // Memory model: beats and acks every other cycle
    assign mem_rd_data = mem[{mem_rd_addr[9:4], beat[1:0]}];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
            mem_rd_valid <= 1'b0; mem_wr_ack <= 1'b0; beat <= '0;
            rd_cnt <= 0; wr_cnt <= 0;
        end else begin
            mem_rd_valid <= mem_rd_req && !mem_rd_valid;
            if (mem_rd_req && !mem_rd_valid && beat == 3'd0) rd_cnt <= rd_cnt + 1;
            if (!mem_rd_req) beat <= '0;
            else if (mem_rd_valid) beat <= beat + 1'b1;
            mem_wr_ack <= mem_wr_req && !mem_wr_ack;
            if (mem_wr_req && mem_wr_ack) begin
                mem[mem_wr_addr[9:2]] <= mem_wr_data;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] d, output logic [31:0] r);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do @(negedge clk); while (!cpu_ready);
        r = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input int rdd, input string req);
        int r0;
        logic [31:0] r;
        r0 = rd_cnt;
        do_op(1'b0, a, 32'h0, r);
        chk(r == exp, req, r, exp);
        chk(rd_cnt - r0 == rdd, {req, " refills"}, rd_cnt - r0, rdd);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input int wrd, input string req);
        int w0;
        logic [31:0] r;
        w0 = wr_cnt;
        do_op(1'b1, a, d, r);
        chk(wr_cnt - w0 == wrd, {req, " mem writes"}, wr_cnt - w0, wrd);
    endtask

    task automatic maint(input logic [1:0] op, input logic [IDX_W-1:0] idx, input logic way);
        @(posedge clk); #1;
        maint_op = op; maint_idx = idx; maint_way = way;
        @(posedge clk); #1;
        maint_op = 2'd0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  rd_d;
        logic [3:0]  wr_d;
    } vec_t;

    // Main function: fills, hits, write-through, no-allocate, LRU (R2 R3 R4)
    localparam vec_t VECS [10] = '{
        '{1'b0, 32'h000, 32'h0,         32'hA000_0000, 4'd1, 4'd0},
        '{1'b0, 32'h008, 32'h0,         32'hA000_0002, 4'd0, 4'd0},
        '{1'b1, 32'h004, 32'h1111_1111, 32'h0,         4'd0, 4'd1},
        '{1'b0, 32'h004, 32'h0,         32'h1111_1111, 4'd0, 4'd0},
        '{1'b1, 32'h100, 32'h2222_2222, 32'h0,         4'd0, 4'd1},
        '{1'b0, 32'h104, 32'h0,         32'hA000_0041, 4'd1, 4'd0},
        '{1'b0, 32'h000, 32'h0,         32'hA000_0000, 4'd0, 4'd0},
        '{1'b0, 32'h040, 32'h0,         32'hA000_0010, 4'd1, 4'd0},
        '{1'b0, 32'h000, 32'h0,         32'hA000_0000, 4'd0, 4'd0},
        '{1'b0, 32'h100, 32'h0,         32'h2222_2222, 4'd1, 4'd0}
    };

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        finish_run();
    end

    initial begin
        int r0, w0;
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet outputs while and after reset
        chk(!cpu_ready && !mem_rd_req && !mem_wr_req, "R1 reset outputs",
            {cpu_ready, mem_rd_req, mem_wr_req}, 0);
        @(posedge clk); #1; rst_n = 1'b1; cache_en = 1'b1;
        repeat (2) @(posedge clk);

        foreach (VECS[i]) begin
            if (VECS[i].we) wr(VECS[i].addr, VECS[i].wdata, int'(VECS[i].wr_d), "R3 table write");
            else rd(VECS[i].addr, VECS[i].exp, int'(VECS[i].rd_d), "R4 table read");
        end

        // R5: lock only the first fill of set 1
        lock_en = 1'b1;
        rd(32'h010, 32'hA000_0004, 1, "R5 locked fill");
        rd(32'h050, 32'hA000_0014, 1, "R5 second fill");
        lock_en = 1'b0;
        // R6: write hit on locked line stays local
        wr(32'h010, 32'h33, 0, "R6 locked write");
        chk(mem[4] == 32'hA000_0004, "R6 memory untouched", mem[4], 32'hA000_0004);
        rd(32'h010, 32'h33, 0, "R6 readback");
        wr(32'h050, 32'h44, 1, "R5 second way unlocked");
        // R7: locked way survives misses to its set
        rd(32'h090, 32'hA000_0024, 1, "R7 miss into set");
        rd(32'h010, 32'h33, 0, "R7 locked kept");
        rd(32'h0D0, 32'hA000_0034, 1, "R7 miss again");
        rd(32'h010, 32'h33, 0, "R7 locked kept again");

        // R8: invalidate-all spares locked lines
        maint(2'd3, '0, 1'b0);
        rd(32'h000, 32'hA000_0000, 1, "R8 unlocked dropped");
        rd(32'h010, 32'h33, 0, "R8 locked kept");

        // R9: invalidate locked line without clearing lock
        maint(2'd1, 2'd1, 1'b0);
        rd(32'h010, 32'h33, 0, "R9 read still hits");
        wr(32'h010, 32'h55, 1, "R9 write reaches memory");
        chk(mem[4] == 32'h55, "R9 memory value", mem[4], 32'h55);
        rd(32'h010, 32'h55, 0, "R9 cached word updated");
        maint(2'd2, 2'd1, 1'b0);
        rd(32'h010, 32'h55, 1, "R9 line gone after lock clear");

        // R10: lock clear loses nothing in cache but writes nothing
        lock_en = 1'b1;
        rd(32'h020, 32'hA000_0008, 1, "R10 locked fill");
        lock_en = 1'b0;
        wr(32'h020, 32'h66, 0, "R10 cache-only write");
        w0 = wr_cnt;
        maint(2'd2, 2'd2, 1'b0);
        chk(wr_cnt == w0, "R10 no write on clear", wr_cnt, w0);
        chk(mem[8] == 32'hA000_0008, "R10 memory stale", mem[8], 32'hA000_0008);
        rd(32'h024, 32'hA000_0009, 0, "R10 line still valid");
        rd(32'h020, 32'h66, 0, "R10 cached data kept");
        wr(32'h020, 32'h77, 1, "R10 now write-through");

        // R12: maintenance beats a simultaneous read
        @(posedge clk); #1;
        r0 = rd_cnt;
        maint_op = 2'd1; maint_idx = 2'd2; maint_way = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h024;
        @(negedge clk);
        chk(!cpu_ready, "R12 request stalled", cpu_ready, 0);
        @(posedge clk); #1; maint_op = 2'd0;
        do @(negedge clk); while (!cpu_ready);
        chk(cpu_rdata == 32'hA000_0009, "R12 read after maint", cpu_rdata, 32'hA000_0009);
        @(posedge clk); #1; cpu_req = 1'b0;
        chk(rd_cnt - r0 == 1, "R12 line invalidated first", rd_cnt - r0, 1);

        // R11: disabled cache bypasses, enable waits for idle
        cache_en = 1'b0;
        repeat (2) @(posedge clk);
        rd(32'h000, 32'hA000_0000, 1, "R11 disabled read");
        rd(32'h000, 32'hA000_0000, 1, "R11 disabled read again");
        fork
            do_op(1'b0, 32'h0C0, 32'h0, r);
            begin repeat (3) @(posedge clk); #2 cache_en = 1'b1; end
        join
        chk(r == 32'hA000_0030, "R11 bypass data", r, 32'hA000_0030);
        rd(32'h0C0, 32'hA000_0030, 1, "R11 no allocation mid-refill");
        rd(32'h0C0, 32'hA000_0030, 0, "R11 enabled hit");

        finish_run();
    end
endmodule